// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synchronous static RAM whose data bus never needs an idle cycle when traffic switches between reading and writing. Every control, address and data input is captured on the rising clock edge. A write presents its address on one edge and its data one or two enabled edges later. Until that data arrives, the write waits in a short pipeline, and the array is updated from the same edge with no external write strobe. A read that lands on an address with a write still in flight returns the new data, merged lane by lane.

A static mode pin selects one of two timings. In pipelined mode, write data follows its address by two edges and read data is held in an output register. In flow-through mode, write data follows by one edge and read data comes straight from the array. A four-beat burst sequencer can step the two low address bits in linear or interleaved order. Three chip selects support depth expansion. A clock enable freezes the whole block. An asynchronous output enable can shut off the output drivers at any moment.

Top module: `zt_sram`

## Requirements
- R1: A new command is accepted only when `cs_pri_n`=0, `cs_hi`=1 and `cs_lo_n`=0 while `adv`=0. Any other pattern is a deselect, and `q_oe` is 0 in the cycle where a read's data would have appeared.
- R2: In pipelined mode (`flow_mode`=0), a read sampled on enabled edge n drives `q_oe`=1 and the word on `q` after enabled edge n+1, until the next enabled edge.
- R3: In flow-through mode (`flow_mode`=1), a read sampled on enabled edge n drives `q_oe`=1 and the word on `q` after edge n itself, until the next enabled edge.
- R4: In pipelined mode, write data is taken from `din` on enabled edge n+2 for a write sampled on edge n. Only the lanes whose `lane_we` bit is 1 are stored: bit l covers `din[9l+8:9l]`.
- R5: In flow-through mode, write data is taken from `din` on enabled edge n+1 for a write sampled on edge n, with the same lane rule as R4.
- R6: Reads and writes may alternate on consecutive edges. A read that follows a write to the same address returns the written lanes merged over the old contents.
- R7: With `burst_ilv`=0, each `adv`=1 cycle continues the last command (same direction) at low address bits (start+k) mod 4 for beat k. The upper address bits are kept and the count wraps after beat 3.
- R8: With `burst_ilv`=1, the low address bits of beat k are start XOR k.
- R9: While `clk_en`=0, no input is sampled, the array is not written, and `q`/`q_oe` keep their values.
- R10: `oe`=0 forces `q_oe`=0 and `q`=0 immediately, whatever read is in progress.
- R11: After reset `q_oe` is 0. An `adv`=1 cycle with no burst open (after reset or after a deselect) is a deselect.
- R12: A deselect that follows a write does not cancel it. The data is still taken at its normal edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline and burst state |
| clk_en | input | 1 | 1 = this edge counts; 0 = freeze everything |
| flow_mode | input | 1 | Static mode: 0 pipelined, 1 flow-through |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| cs_pri_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = continue open burst instead of loading a new address |
| wr | input | 1 | 1 = write command, 0 = read command |
| lane_we | input | LANES | Per-lane write enable, one bit per 9-bit lane |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data bus (late) |
| oe | input | 1 | Asynchronous output enable |
| q | output | DATA_W | Read data, 0 while not driven |
| q_oe | output | 1 | Output driver enable; 0 means high impedance |

## Verification
The bench targets the read that lands one cycle after a write to the same word in pipelined mode. A design without forwarding would return the stale word there, and one that forwarded without lane masking would corrupt the untouched lane. Bursts start at low bits 1 and 2 so that wrap and XOR order are both visible; a wrong sequencer would read the neighbouring word. Stall cycles carry write commands and fresh `din`, so a block that leaks writes or moves its pipeline under a low clock enable shows wrong data later. Deselects placed between a write and its data catch a design that drops the pending write.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  // Low two address bits for beat k of a four-beat burst.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              burst_ilv,
  input  logic              sel,
  input  logic              adv,
  input  logic              wr,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_vld,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_be
);
  import zt_sram_pkg::*;

  logic              act_q;
  logic              wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic [1:0]        beat_nx;

  assign beat_nx = beat_q + 2'd1;
  assign cmd_be  = lane_we;

  always_comb begin
    cmd_vld  = 1'b0;
    cmd_wr   = wr;
    cmd_addr = addr;
    if (adv) begin
      cmd_vld  = act_q;
      cmd_wr   = wr_q;
      cmd_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], beat_nx, burst_ilv)};
    end else if (sel) begin
      cmd_vld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
    end else if (clk_en) begin
      if (adv) begin
        if (act_q) beat_q <= beat_nx;
      end else if (sel) begin
        act_q  <= 1'b1;
        wr_q   <= wr;
        base_q <= addr;
        beat_q <= '0;
      end else begin
        act_q <= 1'b0;
      end
    end
  end

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv && act_q) |=> (beat_q == $past(beat_q) + 2'd1)); // R7
  AST_BURST_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv && sel) |=> (act_q && beat_q == 2'd0)); // R8
  AST_NO_ORPHAN_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !act_q) |-> !cmd_vld); // R11

endmodule

// File: rtl/zt_late_pipe.sv
module zt_late_pipe #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              flow_mode,
  input  logic              cmd_vld,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  cmd_be,
  output logic              a_vld,
  output logic              a_wr,
  output logic [ADDR_W-1:0] a_addr,
  output logic              b_vld,
  output logic              b_wr,
  output logic [ADDR_W-1:0] b_addr,
  output logic [LANES-1:0]  b_be,
  output logic              wen,
  output logic [ADDR_W-1:0] waddr,
  output logic [LANES-1:0]  wbe
);
  logic [LANES-1:0] a_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld  <= 1'b0;
      a_wr   <= 1'b0;
      a_addr <= '0;
      a_be   <= '0;
      b_vld  <= 1'b0;
      b_wr   <= 1'b0;
      b_addr <= '0;
      b_be   <= '0;
    end else if (clk_en) begin
      a_vld  <= cmd_vld;
      a_wr   <= cmd_wr;
      a_addr <= cmd_addr;
      a_be   <= cmd_be;
      b_vld  <= a_vld;
      b_wr   <= a_wr;
      b_addr <= a_addr;
      b_be   <= a_be;
    end
  end

  // Write commits in the edge that brings its data: one stage late in
  // flow-through mode, two stages late in pipelined mode.
  assign wen   = clk_en && (flow_mode ? (a_vld && a_wr) : (b_vld && b_wr));
  assign waddr = flow_mode ? a_addr : b_addr;
  assign wbe   = flow_mode ? a_be   : b_be;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(a_vld) && $stable(b_vld) && $stable(a_addr) && $stable(b_addr))); // R9
  AST_WRITE_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && a_vld && a_wr) |=> (b_vld && b_wr)); // R12

endmodule

// File: rtl/zt_store.sv
module zt_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              wen,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wbe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wen && wbe[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end
    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end

  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wen |-> clk_en); // R9

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              flow_mode,
  input  logic              burst_ilv,
  input  logic              cs_pri_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              adv,
  input  logic              wr,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              oe,
  output logic [DATA_W-1:0] q,
  output logic              q_oe
);
  logic              sel;
  logic              cmd_vld, cmd_wr;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_be;
  logic              a_vld, a_wr, b_vld, b_wr;
  logic [ADDR_W-1:0] a_addr, b_addr, waddr;
  logic [LANES-1:0]  b_be, wbe;
  logic              wen;
  logic [DATA_W-1:0] rdata;
  logic              fwd_hit;
  logic [DATA_W-1:0] rd_merged;
  logic              q_vld;
  logic [DATA_W-1:0] q_reg;
  logic              rd_drive;
  logic [DATA_W-1:0] rd_word;

  assign sel = !cs_pri_n && cs_hi && !cs_lo_n;

  zt_burst_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .burst_ilv(burst_ilv),
    .sel(sel), .adv(adv), .wr(wr), .lane_we(lane_we), .addr(addr),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_be(cmd_be));

  zt_late_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .flow_mode(flow_mode),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_be(cmd_be),
    .a_vld(a_vld), .a_wr(a_wr), .a_addr(a_addr),
    .b_vld(b_vld), .b_wr(b_wr), .b_addr(b_addr), .b_be(b_be),
    .wen(wen), .waddr(waddr), .wbe(wbe));

  zt_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wen(wen), .waddr(waddr),
    .wbe(wbe), .wdata(din), .raddr(a_addr), .rdata(rdata));

  // Pipelined read sampling the array on the same edge that commits an
  // older write to that word: take the arriving lanes from din.
  assign fwd_hit = b_vld && b_wr && (b_addr == a_addr);

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rd_merged[l*LANE_W +: LANE_W] = (fwd_hit && b_be[l]) ? din[l*LANE_W +: LANE_W]
                                                           : rdata[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_vld <= 1'b0;
    else if (clk_en) q_vld <= a_vld && !a_wr;
  end

  always_ff @(posedge clk) begin
    if (clk_en) q_reg <= rd_merged;
  end

  assign rd_drive = flow_mode ? (a_vld && !a_wr) : q_vld;
  assign rd_word  = flow_mode ? rdata : q_reg;
  assign q_oe     = rd_drive && oe;
  assign q        = q_oe ? rd_word : '0;

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv && !sel) |=> !a_vld); // R1
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !flow_mode && a_vld && a_wr) |=> !q_vld); // R2
  AST_FLOW_FROM_A: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && wen) |-> (a_vld && a_wr && waddr == a_addr)); // R5

endmodule

// File: tb/zt_sram_tb.sv
module zt_sram_tb;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0, flow_mode = 1'b0, burst_ilv = 1'b0;
  logic cs_pri_n = 1'b1, cs_hi = 1'b0, cs_lo_n = 1'b1, adv = 1'b0, wr = 1'b0, oe = 1'b1;
  logic [LANES-1:0]  lane_we = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] q;
  logic              q_oe;

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_tag = "R11";

  // reference model state
  logic [DATA_W-1:0] m_mem [DEPTH];
  bit                h_vld [4];
  bit                h_wr  [4];
  logic [ADDR_W-1:0] h_addr[4];
  logic [LANES-1:0]  h_be  [4];
  int                ecnt;
  bit                exp_drive;
  logic [DATA_W-1:0] exp_val;
  bit                bb_act, bb_wr;
  logic [ADDR_W-1:0] bb_base;
  int                bb_k;

  always #(CLK_P/2) clk = ~clk;

  zt_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .flow_mode(flow_mode),
    .burst_ilv(burst_ilv), .cs_pri_n(cs_pri_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .adv(adv), .wr(wr), .lane_we(lane_we), .addr(addr), .din(din), .oe(oe),
    .q(q), .q_oe(q_oe));

  function automatic bit f_sel(input bit p, input bit h, input bit l);
    return (p == 1'b0) && (h == 1'b1) && (l == 1'b0);
  endfunction

  function automatic logic [1:0] f_low(input logic [1:0] s, input int k, input bit ilv);
    logic [1:0] kb;
    kb = 2'(k);
    if (ilv) return {s[1] ^ kb[1], s[0] ^ kb[0]};
    return 2'((int'(s) + k) % 4);
  endfunction

  function automatic logic [DATA_W-1:0] f_merge(input logic [DATA_W-1:0] old,
                                                input logic [DATA_W-1:0] nw,
                                                input logic [LANES-1:0] be);
    logic [DATA_W-1:0] r;
    r = old;
    for (int l = 0; l < LANES; l++)
      if (be[l]) r[l*LANE_W +: LANE_W] = nw[l*LANE_W +: LANE_W];
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin h_vld[i] = 1'b0; h_wr[i] = 1'b0; end
    ecnt = 0; exp_drive = 1'b0; exp_val = '0; bb_act = 1'b0; bb_wr = 1'b0; bb_k = 0;
  endtask

  task automatic chk(input logic [DATA_W:0] act, input logic [DATA_W:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got q_oe=%0b q=%h, expected q_oe=%0b q=%h",
               tag, act[DATA_W], act[DATA_W-1:0], exp[DATA_W], exp[DATA_W-1:0]);
    end
  endtask

  // one clock: drive at negedge, model the edge, check at next negedge
  task automatic cyc(input bit ce, input bit p, input bit h, input bit l, input bit a,
                     input bit w, input logic [LANES-1:0] be, input logic [ADDR_W-1:0] ad,
                     input logic [DATA_W-1:0] d, input bit o);
    bit v, ww;
    logic [ADDR_W-1:0] ea;
    int idx, lat, j;
    logic [DATA_W-1:0] ev;
    clk_en = ce; cs_pri_n = p; cs_hi = h; cs_lo_n = l; adv = a; wr = w;
    lane_we = be; addr = ad; din = d; oe = o;
    @(posedge clk);
    if (ce) begin
      if (a) begin
        v = bb_act; ww = bb_wr;
        if (bb_act) bb_k = (bb_k + 1) % 4;
        ea = {bb_base[ADDR_W-1:2], f_low(bb_base[1:0], bb_k, burst_ilv)};
      end else if (f_sel(p, h, l)) begin
        v = 1'b1; ww = w; ea = ad;
        bb_act = 1'b1; bb_wr = w; bb_base = ad; bb_k = 0;
      end else begin
        v = 1'b0; ww = 1'b0; ea = ad; bb_act = 1'b0;
      end
      idx = ecnt % 4;
      h_vld[idx] = v; h_wr[idx] = ww; h_addr[idx] = ea; h_be[idx] = be;
      lat = flow_mode ? 0 : 1;
      if (ecnt >= lat + 1) begin
        j = (ecnt - lat - 1) % 4;
        if (h_vld[j] && h_wr[j]) m_mem[h_addr[j]] = f_merge(m_mem[h_addr[j]], d, h_be[j]);
      end
      if (ecnt >= lat) begin
        j = (ecnt - lat) % 4;
        exp_drive = h_vld[j] && !h_wr[j];
        exp_val   = m_mem[h_addr[j]];
      end else begin
        exp_drive = 1'b0;
      end
      ecnt++;
    end
    @(negedge clk);
    ev = (exp_drive && o) ? exp_val : '0;
    chk({q_oe, q}, {exp_drive && o, ev}, cur_tag);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] ad);
    cyc(1, 0, 1, 0, 0, 0, '0, ad, DATA_W'($urandom), 1);
  endtask
  task automatic wt(input logic [ADDR_W-1:0] ad, input logic [LANES-1:0] be, input logic [DATA_W-1:0] d);
    cyc(1, 0, 1, 0, 0, 1, be, ad, d, 1);
  endtask
  task automatic idle(input logic [DATA_W-1:0] d);
    cyc(1, 1, 0, 1, 0, 0, '0, '0, d, 1);
  endtask
  task automatic step(input logic [DATA_W-1:0] d);
    cyc(1, 1, 0, 1, 1, 0, 2'b11, '0, d, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; clk_en = 1'b1; adv = 1'b0; cs_pri_n = 1'b1; cs_hi = 1'b0; cs_lo_n = 1'b1; oe = 1'b1;
    repeat (3) @(negedge clk);
    chk({q_oe, q}, {1'b0, {DATA_W{1'b0}}}, "R11 reset");
    model_reset();
    rst_n = 1'b1;
  endtask

  task automatic rnd_phase(input int n);
    for (int i = 0; i < n; i++) begin
      bit ce, p, h, l, a, w, o, all;
      ce = ($urandom % 10) != 0;
      all = ($urandom % 8) != 0;
      p = all ? 1'b0 : 1'($urandom);
      h = all ? 1'b1 : 1'($urandom);
      l = all ? 1'b0 : 1'($urandom);
      a = ($urandom % 4) == 0;
      w = 1'($urandom);
      o = ($urandom % 10) != 0;
      cyc(ce, p, h, l, a, w, LANES'($urandom), ADDR_W'($urandom % 16), DATA_W'($urandom), o);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd24681);
    do_reset();

    // preload every word, pipelined timing, full lanes (R4)
    cur_tag = "R4";
    for (int i = 0; i < DEPTH; i++) wt(ADDR_W'(i), 2'b11, DATA_W'(i * 977 + 5));
    idle(18'h1_2345); idle(18'h0_0F0F); idle('0);

    // write then read same word at once: bypass with lane mask (R6, R4)
    cur_tag = "R6";
    wt(6'd5, 2'b01, '0);
    rd(6'd5);
    rd(6'd5);
    idle(18'h3_3333);
    wt(6'd9, 2'b10, '0); rd(6'd9); wt(6'd9, 2'b01, '0); rd(6'd9);
    cyc(1, 0, 1, 0, 0, 0, '0, 6'd9, 18'h2_AAAA, 1);
    cyc(1, 1, 0, 1, 0, 0, '0, 6'd9, 18'h1_5555, 1);
    idle('0); idle('0);

    // deselect patterns with one enable wrong (R1)
    cur_tag = "R1";
    rd(6'd3);
    cyc(1, 1, 1, 0, 0, 0, '0, 6'd3, '0, 1);
    cyc(1, 0, 0, 0, 0, 0, '0, 6'd3, '0, 1);
    cyc(1, 0, 1, 1, 0, 0, '0, 6'd3, '0, 1);
    idle('0);

    // deselect between a write and its data (R12)
    cur_tag = "R12";
    wt(6'd7, 2'b11, '0);
    idle('0);
    idle(18'h0_BEEF);
    rd(6'd7); idle('0); idle('0);

    // advance with no open burst (R11)
    cur_tag = "R11";
    idle('0); step('0); step('0); idle('0);

    // linear burst from low bits 2, read and write (R7)
    cur_tag = "R7";
    rd(6'd6); step('0); step('0); step('0); step('0); idle('0); idle('0);
    wt(6'd13, 2'b11, '0); step('0); step(18'h1_1111); step(18'h2_2222);
    idle(18'h3_3333); idle(18'h0_4444);
    rd(6'd12); step('0); step('0); step('0); idle('0); idle('0);

    // output enable drops mid read (R10)
    cur_tag = "R10";
    rd(6'd2);
    cyc(1, 0, 1, 0, 0, 0, '0, 6'd4, '0, 0);
    cyc(1, 0, 1, 0, 0, 0, '0, 6'd4, '0, 0);
    cyc(1, 1, 0, 1, 0, 0, '0, 6'd4, '0, 1);
    idle('0);

    // stall with a write attempt and fresh din (R9)
    cur_tag = "R9";
    wt(6'd11, 2'b11, '0); rd(6'd10);
    cyc(0, 0, 1, 0, 0, 1, 2'b11, 6'd10, 18'h0_DEAD, 1);
    cyc(0, 0, 1, 0, 0, 1, 2'b11, 6'd10, 18'h1_0BAD, 1);
    idle(18'h2_CAFE);
    cyc(0, 0, 1, 0, 0, 0, '0, 6'd11, 18'h0_0001, 1);
    rd(6'd11); rd(6'd10); idle('0); idle('0);

    cur_tag = "R2";
    rnd_phase(300);

    // interleaved order, pipelined (R8)
    do_reset();
    burst_ilv = 1'b1;
    cur_tag = "R8";
    rd(6'd1); step('0); step('0); step('0); idle('0); idle('0);
    rd(6'd14); step('0); step('0); step('0); step('0); idle('0); idle('0);
    rnd_phase(300);

    // flow-through mode (R5, R3)
    do_reset();
    flow_mode = 1'b1; burst_ilv = 1'b0;
    cur_tag = "R5";
    wt(6'd8, 2'b01, '0); rd(6'd8);
    wt(6'd8, 2'b10, 18'h1_7777); rd(6'd8);
    cyc(1, 0, 1, 0, 0, 0, '0, 6'd8, 18'h0_0999, 1);
    idle('0); idle('0);
    cur_tag = "R3";
    rd(6'd6); step('0); step('0); step('0); idle('0);
    rnd_phase(300);

    do_reset();
    burst_ilv = 1'b1;
    cur_tag = "R8";
    rd(6'd3); step('0); step('0); step('0); idle('0);
    cur_tag = "R3";
    rnd_phase(300);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): got running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule